// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a compact multicycle processor built around a single 16-bit accumulator. It walks through register-transfer steps to bring each instruction in from memory, decode it and carry it out. Every memory access goes through a 12-bit address register and a 16-bit data register. The instruction set has four defined operations: load, add, store and halt. Every other opcode does nothing, and the next fetch follows.

The block drives one synchronous single-port word memory. That memory returns read data one cycle after it samples the address. After a halt, the block parks until reset. The accumulator and a halted flag are visible at the ports, so a test environment can read the outcome of a program.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator reads 0 and halted reads 0. The program counter restarts at 0, so the first instruction executed is the word at address 0.
- R2: An instruction word splits into two fields. The opcode is bits [15:12] and the operand address is bits [11:0].
- R3: Opcode 4'b0001 (load) replaces the accumulator with the memory word at the operand address.
- R4: Opcode 4'b0011 (add) adds the memory word at the operand address to the accumulator, modulo 2^16. The carry out is discarded.
- R5: Opcode 4'b0100 (store) asserts mem_we for exactly one cycle. During that cycle mem_addr holds the operand address and mem_wdata holds the accumulator. No other instruction writes memory.
- R6: Opcode 4'b0111 (halt) sets halted. From then until reset there are no writes, and the accumulator does not change.
- R7: The program counter advances by exactly 1 per fetched instruction. Instructions execute in address order.
- R8: Each instruction takes a fixed number of cycles from the start of its fetch to the start of the next fetch. Load and add take 8 cycles, store takes 6, and an instruction with no memory operand takes 5. Halted rises 5 cycles after the halt's fetch begins. Reset release takes 2 further cycles to reach the first fetch.
- R9: Any opcode other than 0001, 0011, 0100 and 0111 is a no-operation. It leaves the accumulator unchanged, performs no write, and continues with the next fetch.
- R10: Memory reads are sampled one cycle after the address register is loaded. The instruction address comes from the program counter, and the operand address comes from the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| halted | output | 1 | High once a halt has executed |
| acc_out | output | 16 | Current accumulator value |

## Verification
The bench uses the default parameters: a 12-bit address, a 16-bit word and a two-stage reset synchronizer. The 12-bit address lets the bench keep programs in low memory and data at 0x800 and above, so stores never overwrite code. The 16-bit word means operands such as 0xFFFF and 0x7FFF make the dropped carry and the sign wrap directly visible. Random programs mix all four operations with unlisted opcodes. Each run is compared against a bench model on final accumulator, data memory, write count and exact cycle count.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'b0111;

  typedef enum logic [3:0] {
    S_FA   = 4'd0,  // address register <- program counter
    S_FW   = 4'd1,  // memory read latency
    S_FD   = 4'd2,  // data register <- memory
    S_FI   = 4'd3,  // instruction register <- data register, pc + 1
    S_DEC  = 4'd4,  // decode, address register <- operand field
    S_OW   = 4'd5,  // operand read latency
    S_OD   = 4'd6,  // data register <- operand
    S_EX   = 4'd7,  // accumulator update
    S_ST   = 4'd8,  // write cycle
    S_HALT = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_load;
    logic ir_load;
    logic pc_inc;
    logic acc_load;
    logic acc_add;
    logic mem_we;
  } seq_ctl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [OPC_W-1:0]       opcode,
  output seq_state_e             state,
  output seq_ctl_t               ctl
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    unique case (state_q)
      S_FA: begin
        ctl.mar_from_pc = 1'b1;
        state_d         = S_FW;
      end
      S_FW: state_d = S_FD;
      S_FD: begin
        ctl.mdr_load = 1'b1;
        state_d      = S_FI;
      end
      S_FI: begin
        ctl.ir_load = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_d     = S_DEC;
      end
      S_DEC: begin
        case (opcode)
          OPC_LOAD, OPC_ADD: begin
            ctl.mar_from_ir = 1'b1;
            state_d         = S_OW;
          end
          OPC_STORE: begin
            ctl.mar_from_ir = 1'b1;
            state_d         = S_ST;
          end
          OPC_HALT: state_d = S_HALT;
          default:  state_d = S_FA;
        endcase
      end
      S_OW: state_d = S_OD;
      S_OD: begin
        ctl.mdr_load = 1'b1;
        state_d      = S_EX;
      end
      S_EX: begin
        ctl.acc_load = 1'b1;
        ctl.acc_add  = (opcode == OPC_ADD);
        state_d      = S_FA;
      end
      S_ST: begin
        ctl.mem_we = 1'b1;
        state_d    = S_FA;
      end
      S_HALT: state_d = S_HALT;
      default: state_d = S_FA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FA;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  seq_ctl_t          ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic [OPC_W-1:0]  opcode
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic [DATA_W-1:0] acc_d;

  always_comb begin
    if (ctl.acc_add) acc_d = acc_q + mdr_q;
    else             acc_d = mdr_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (ctl.pc_inc)           pc_q  <= pc_q + 1'b1;
      if (ctl.mar_from_pc)      mar_q <= pc_q;
      else if (ctl.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (ctl.mdr_load)         mdr_q <= mem_rdata;
      if (ctl.ir_load)          ir_q  <= mdr_q;
      if (ctl.acc_load)         acc_q <= acc_d;
    end
  end

  assign mar    = mar_q;
  assign pc     = pc_q;
  assign ir     = ir_q;
  assign acc    = acc_q;
  assign opcode = ir_q[DATA_W-1 -: OPC_W];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int RST_STAGES = 2,
  localparam int DATA_W    = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out
);

  logic              rst_i_n;
  seq_state_e        state_q;
  seq_ctl_t          ctl;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;

  acc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  acc_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_ni(rst_i_n),
    .opcode(opcode),
    .state (state_q),
    .ctl   (ctl)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .ctl      (ctl),
    .mem_rdata(mem_rdata),
    .mar      (mem_addr),
    .pc       (pc_q),
    .ir       (ir_q),
    .acc      (acc_q),
    .opcode   (opcode)
  );

  assign mem_we    = ctl.mem_we;
  assign mem_wdata = acc_q;
  assign acc_out   = acc_q;
  assign halted    = (state_q == S_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        state,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] acc_out
);

  // R7: one increment per fetched instruction
  a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FI) |=> (pc == $past(pc) + 1'b1));

  // R7: program counter is otherwise held
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_FI) |=> $stable(pc));

  // R10: instruction read addresses the program counter
  a_r10_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FW) |-> (mem_addr == pc));

  // R10: operand read addresses the instruction's field
  a_r10_operand_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OW) |-> (mem_addr == ir[ADDR_W-1:0]));

  // R5: write strobe lasts one cycle
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5: write targets the operand address
  a_r5_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == ir[ADDR_W-1:0]));

  // R6: halt is sticky, silent and freezes the accumulator
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(acc_out)));

  // R9: accumulator changes only in the execute step
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_EX) |=> $stable(acc_out));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (state_q),
  .pc      (pc_q),
  .ir      (ir_q),
  .mem_addr(mem_addr),
  .mem_we  (mem_we),
  .halted  (halted),
  .acc_out (acc_out)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int RST_LAT = 2;
  localparam int DATA_BASE = 12'h800;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          halted;
  logic [DW-1:0] acc_out;

  logic [DW-1:0] mem     [0:(1<<AW)-1];
  logic [DW-1:0] exp_mem [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  acc_cpu u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .halted   (halted),
    .acc_out  (acc_out)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  function automatic logic [3:0] unlisted_op();
    logic [3:0] o;
    do o = 4'($urandom); while (o == 4'h1 || o == 4'h3 || o == 4'h4 || o == 4'h7);
    return o;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i] = '0;
      exp_mem[i] = '0;
    end
  endtask

  task automatic put(input int a, input logic [DW-1:0] w);
    mem[a] = w;
    exp_mem[a] = w;
  endtask

  // Model from the requirements: R2 fields, R3/R4/R5/R9 effects, R8 costs
  task automatic model(output logic [DW-1:0] eacc, output int ecyc, output int ewr);
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] w;
    bit done = 0;
    eacc = '0; ecyc = 0; ewr = 0;
    for (int s = 0; s < (1<<AW) && !done; s++) begin
      w = exp_mem[pc];
      pc = pc + 1'b1;
      case (w[15:12])
        4'h1: begin eacc = exp_mem[w[11:0]]; ecyc += 8; end
        4'h3: begin eacc = eacc + exp_mem[w[11:0]]; ecyc += 8; end
        4'h4: begin exp_mem[w[11:0]] = eacc; ewr++; ecyc += 6; end
        4'h7: begin ecyc += 5; done = 1; end
        default: ecyc += 5;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(acc_out == '0, "R1 acc in reset", int'(acc_out), 0);
    check(!halted, "R1 halted in reset", int'(halted), 0);
    rst_n = 1'b1;
  endtask

  // Runs the loaded program and checks it against the model
  task automatic run_prog(output logic [DW-1:0] got_acc);
    logic [DW-1:0] eacc;
    int ecyc, ewr, n, wr, mism;
    logic [DW-1:0] acc_h;
    model(eacc, ecyc, ewr);
    do_reset();
    n = 0; wr = 0;
    while (!halted && n < 20000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (mem_we) wr++;
    end
    check(halted, "R6 halted reached", int'(halted), 1);
    check(n == ecyc + RST_LAT, "R8 R10 cycle count", n, ecyc + RST_LAT);
    check(acc_out == eacc, "R3 R4 R7 final acc", int'(acc_out), int'(eacc));
    check(wr == ewr, "R5 R9 write cycles", wr, ewr);
    mism = 0;
    for (int i = DATA_BASE; i < (1<<AW); i++) if (mem[i] !== exp_mem[i]) mism++;
    check(mism == 0, "R5 data memory mismatches", mism, 0);
    acc_h = acc_out;
    repeat (12) begin
      @(negedge clk);
      if (mem_we) wr++;
    end
    check(halted && acc_out == acc_h && wr == ewr, "R6 halt holds",
          int'(acc_out), int'(acc_h));
    got_acc = acc_out;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;

    // Directed: load, add with dropped carry, store, halt (R2, R3, R4, R5)
    clear_mem();
    put(0, ins(4'h1, 12'h800));
    put(1, ins(4'h3, 12'h801));
    put(2, ins(4'h4, 12'h802));
    put(3, ins(4'h7, 12'h000));
    put(12'h800, 16'h0023);
    put(12'h801, 16'hFFE9);
    run_prog(r);
    check(r == 16'h000C, "R4 carry dropped", int'(r), 16'h000C);
    check(mem[12'h802] == 16'h000C, "R5 stored word", int'(mem[12'h802]), 16'h000C);

    // Directed: signed wrap and double 0xFFFF (R4)
    clear_mem();
    put(0, ins(4'h1, 12'h810));
    put(1, ins(4'h3, 12'h811));
    put(2, ins(4'h4, 12'h812));
    put(3, ins(4'h1, 12'h813));
    put(4, ins(4'h3, 12'h813));
    put(5, ins(4'h7, 12'h000));
    put(12'h810, 16'h7FFF);
    put(12'h811, 16'h0001);
    put(12'h813, 16'hFFFF);
    run_prog(r);
    check(mem[12'h812] == 16'h8000, "R4 signed wrap", int'(mem[12'h812]), 16'h8000);
    check(r == 16'hFFFE, "R4 all ones sum", int'(r), 16'hFFFE);

    // Directed: every unlisted opcode is a no-operation (R9, R8)
    clear_mem();
    put(0, ins(4'h1, 12'h820));
    begin
      int k = 1;
      for (int o = 0; o < 16; o++) begin
        if (o != 1 && o != 3 && o != 4 && o != 7) begin
          put(k, ins(4'(o), 12'h821));
          k++;
        end
      end
      put(k, ins(4'h7, 12'h000));
    end
    put(12'h820, 16'hA5C3);
    put(12'h821, 16'h1111);
    run_prog(r);
    check(r == 16'hA5C3, "R9 no-op keeps acc", int'(r), 16'hA5C3);
    check(mem[12'h821] == 16'h1111, "R9 no-op no write", int'(mem[12'h821]), 16'h1111);

    // Directed: reset during a run clears state and restarts at 0 (R1)
    clear_mem();
    put(0, ins(4'h1, 12'h830));
    for (int i = 1; i < 40; i++) put(i, ins(4'h3, 12'h830));
    put(40, ins(4'h7, 12'h000));
    put(12'h830, 16'h0005);
    do_reset();
    repeat (60) @(negedge clk);
    check(acc_out != '0, "R3 acc loaded mid-run", int'(acc_out), 5);
    run_prog(r);
    check(r == 16'd200, "R1 R7 restart from zero", int'(r), 200);

    // Random programs
    for (int p = 0; p < 30; p++) begin
      int len;
      clear_mem();
      len = 1 + int'($urandom % 24);
      for (int i = 0; i < len; i++) begin
        int sel = int'($urandom % 10);
        logic [AW-1:0] a = 12'(DATA_BASE + ($urandom % 64));
        if (sel < 3)      put(i, ins(4'h1, a));
        else if (sel < 6) put(i, ins(4'h3, a));
        else if (sel < 8) put(i, ins(4'h4, a));
        else              put(i, ins(unlisted_op(), a));
      end
      put(len, ins(4'h7, 12'($urandom)));
      for (int i = 0; i < 64; i++) put(DATA_BASE + i, 16'($urandom));
      run_prog(r);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule